// File: doc/BRIEF.md
# Wavefront Program Counter and Branch Unit

This block holds the program counter of a single wavefront and works out the next fetch address. When a new wave is launched, the counter loads the entry address. Each retired instruction reports its length in 32-bit words and a branch operation. The counter then does one of three things:

- steps past the instruction;
- takes a relative branch, either unconditional or tested against a condition flag;
- handles one of two register operations. Read-PC hands back the following-instruction address. Exchange-PC hands back that address and jumps to an address taken from a register.

All relative arithmetic starts from the address of the instruction after the current one, never from the current one. The two low address bits are cleared on every load, so the counter always holds a word-aligned address.

The decoder drives the branch operation, the 16-bit word offset and the flag inputs. The fetch stage reads `pc_o`. The scalar register file takes `ret_pc_o` whenever `ret_valid_o` pulses.

Top module: `pc_branch_unit`

## Requirements
- R1: While `rst_ni` is low, `pc_o` reads 0 and `ret_valid_o` reads 0.
- R2: A cycle with `wave_start_i` high loads `start_addr_i` into `pc_o`, with bits [1:0] cleared, one clock later. This load takes priority over `instr_valid_i`, and `ret_valid_o` is 0 afterwards.
- R3: An instruction with `br_op_i`=0 (none), or with an unused code 10 to 15, moves `pc_o` to `pc_o + 4*instr_len_i` one clock later.
- R4: `br_op_i`=1 (jump) sets `pc_o` to `pc_o + 4*instr_len_i + 4*sext(simm_i)`, where `simm_i` is a signed 16-bit word offset. Forward, backward and zero offsets all behave this way.
- R5: A conditional branch takes the R4 target when its flag test holds. The codes are: 2 when `scc_i`=0, 3 when `scc_i`=1, 4 when `vccz_i`=1, 5 when `vccz_i`=0, 6 when `execz_i`=1, and 7 when `execz_i`=0.
- R6: A conditional branch whose test fails behaves as sequential (R3).
- R7: `br_op_i`=8 (read-PC) advances `pc_o` as in R3. One clock later it pulses `ret_valid_o` for one cycle, with `ret_pc_o` = `pc_o + 4*instr_len_i`. No other operation raises `ret_valid_o`.
- R8: `br_op_i`=9 (exchange-PC) pulses `ret_valid_o` with `ret_pc_o` = `pc_o + 4*instr_len_i`. It also sets `pc_o` to `sreg_i` with bits [1:0] cleared.
- R9: Bits [1:0] of `pc_o` and `ret_pc_o` are always 0, whatever address is supplied.
- R10: In a cycle with neither `wave_start_i` nor `instr_valid_i`, `pc_o` does not change and `ret_valid_o` is 0 on the next clock.
- R11: All address arithmetic wraps modulo 2^48.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wave_start_i | input | 1 | Launch a wave at `start_addr_i` |
| start_addr_i | input | 48 | Entry address of the wave |
| instr_valid_i | input | 1 | An instruction retires this cycle |
| instr_len_i | input | 3 | Instruction length in 32-bit words |
| br_op_i | input | 4 | Branch operation code (see R3 to R8) |
| simm_i | input | 16 | Signed word offset for relative branches |
| scc_i | input | 1 | Scalar condition flag |
| vccz_i | input | 1 | Vector condition code is all zero |
| execz_i | input | 1 | Exec mask is all zero |
| sreg_i | input | 48 | Register operand for exchange-PC |
| pc_o | output | 48 | Current fetch address |
| ret_valid_o | output | 1 | `ret_pc_o` is valid this cycle |
| ret_pc_o | output | 48 | Returned following-instruction address |

## Verification
Every result is registered once, so `pc_o`, `ret_valid_o` and `ret_pc_o` reflect a stimulus exactly one rising edge after the cycle in which it was applied. The driver applies each stimulus on a falling edge. It queues the expected values tagged with the edge count at which they fall due. The monitor compares them on the falling edge after that rising edge, never earlier or later. The return outputs are compared only in cycles where a pulse is expected, and the absence of a pulse is checked in every other cycle.

// File: rtl/pcbr_pkg.sv
package pcbr_pkg;
  typedef enum logic [3:0] {
    OP_NONE      = 4'd0,
    OP_JUMP      = 4'd1,
    OP_CB_SCC0   = 4'd2,
    OP_CB_SCC1   = 4'd3,
    OP_CB_VCCZ   = 4'd4,
    OP_CB_VCCNZ  = 4'd5,
    OP_CB_EXECZ  = 4'd6,
    OP_CB_EXECNZ = 4'd7,
    OP_GETPC     = 4'd8,
    OP_SWAPPC    = 4'd9
  } br_op_e;
endpackage

// File: rtl/pcbr_seq_adder.sv
module pcbr_seq_adder #(
  parameter int PC_W  = 48,
  parameter int LEN_W = 3
) (
  input  logic [PC_W-1:0]  pc_i,
  input  logic [LEN_W-1:0] len_i,
  output logic [PC_W-1:0]  seq_o
);
  localparam int PAD_W = PC_W - LEN_W - 2;
  localparam logic [PC_W-1:0] ALIGN_MASK = ~PC_W'(3);

  logic [PC_W-1:0] step_bytes;
  assign step_bytes = {{PAD_W{1'b0}}, len_i, 2'b00};
  assign seq_o      = (pc_i + step_bytes) & ALIGN_MASK;
endmodule

// File: rtl/pcbr_cond_eval.sv
module pcbr_cond_eval
  import pcbr_pkg::*;
(
  input  br_op_e op_i,
  input  logic   scc_i,
  input  logic   vccz_i,
  input  logic   execz_i,
  output logic   take_o
);
  always_comb begin
    unique case (op_i)
      OP_JUMP:      take_o = 1'b1;
      OP_CB_SCC0:   take_o = ~scc_i;
      OP_CB_SCC1:   take_o = scc_i;
      OP_CB_VCCZ:   take_o = vccz_i;
      OP_CB_VCCNZ:  take_o = ~vccz_i;
      OP_CB_EXECZ:  take_o = execz_i;
      OP_CB_EXECNZ: take_o = ~execz_i;
      default:      take_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/pcbr_target.sv
module pcbr_target
  import pcbr_pkg::*;
#(
  parameter int PC_W  = 48,
  parameter int OFS_W = 16
) (
  input  br_op_e            op_i,
  input  logic              take_i,
  input  logic [PC_W-1:0]   seq_i,
  input  logic [OFS_W-1:0]  simm_i,
  input  logic [PC_W-1:0]   sreg_i,
  output logic [PC_W-1:0]   nxt_o,
  output logic              ret_en_o
);
  localparam int EXT_W = PC_W - OFS_W - 2;
  localparam logic [PC_W-1:0] ALIGN_MASK = ~PC_W'(3);

  logic [PC_W-1:0] ofs_bytes;
  logic [PC_W-1:0] rel_tgt;

  // word offset, sign-extended then scaled by 4
  assign ofs_bytes = {{EXT_W{simm_i[OFS_W-1]}}, simm_i, 2'b00};
  assign rel_tgt   = (seq_i + ofs_bytes) & ALIGN_MASK;

  always_comb begin
    nxt_o    = seq_i;
    ret_en_o = 1'b0;
    if (op_i == OP_SWAPPC) begin
      nxt_o    = sreg_i & ALIGN_MASK;
      ret_en_o = 1'b1;
    end else if (op_i == OP_GETPC) begin
      ret_en_o = 1'b1;
    end else if (take_i) begin
      nxt_o = rel_tgt;
    end
  end
endmodule

// File: rtl/pc_branch_unit.sv
module pc_branch_unit
  import pcbr_pkg::*;
#(
  parameter int PC_W  = 48,
  parameter int LEN_W = 3,
  parameter int OFS_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wave_start_i,
  input  logic [PC_W-1:0]  start_addr_i,
  input  logic             instr_valid_i,
  input  logic [LEN_W-1:0] instr_len_i,
  input  logic [3:0]       br_op_i,
  input  logic [OFS_W-1:0] simm_i,
  input  logic             scc_i,
  input  logic             vccz_i,
  input  logic             execz_i,
  input  logic [PC_W-1:0]  sreg_i,
  output logic [PC_W-1:0]  pc_o,
  output logic             ret_valid_o,
  output logic [PC_W-1:0]  ret_pc_o
);
  localparam logic [PC_W-1:0] ALIGN_MASK = ~PC_W'(3);

  br_op_e          op;
  logic [PC_W-1:0] pc_q, ret_q, seq, nxt;
  logic            ret_v_q, take, ret_en;

  assign op = br_op_e'(br_op_i);

  pcbr_seq_adder #(.PC_W(PC_W), .LEN_W(LEN_W)) u_seq (
    .pc_i  (pc_q),
    .len_i (instr_len_i),
    .seq_o (seq)
  );

  pcbr_cond_eval u_cond (
    .op_i    (op),
    .scc_i   (scc_i),
    .vccz_i  (vccz_i),
    .execz_i (execz_i),
    .take_o  (take)
  );

  pcbr_target #(.PC_W(PC_W), .OFS_W(OFS_W)) u_tgt (
    .op_i     (op),
    .take_i   (take),
    .seq_i    (seq),
    .simm_i   (simm_i),
    .sreg_i   (sreg_i),
    .nxt_o    (nxt),
    .ret_en_o (ret_en)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q    <= '0;
      ret_q   <= '0;
      ret_v_q <= 1'b0;
    end else if (wave_start_i) begin
      pc_q    <= start_addr_i & ALIGN_MASK;
      ret_v_q <= 1'b0;
    end else if (instr_valid_i) begin
      pc_q    <= nxt;
      ret_v_q <= ret_en;
      if (ret_en) ret_q <= seq;
    end else begin
      ret_v_q <= 1'b0;
    end
  end

  assign pc_o        = pc_q;
  assign ret_valid_o = ret_v_q;
  assign ret_pc_o    = ret_q;
endmodule

// File: rtl/pcbr_checker.sv
module pcbr_checker
  import pcbr_pkg::*;
#(
  parameter int PC_W  = 48,
  parameter int LEN_W = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wave_start_i,
  input logic [PC_W-1:0]  start_addr_i,
  input logic             instr_valid_i,
  input logic [LEN_W-1:0] instr_len_i,
  input logic [3:0]       br_op_i,
  input logic [PC_W-1:0]  sreg_i,
  input logic [PC_W-1:0]  pc_o,
  input logic             ret_valid_o,
  input logic [PC_W-1:0]  ret_pc_o
);
  logic            instr_go, is_ret_op;
  logic [PC_W-1:0] seq_exp;

  assign instr_go  = instr_valid_i && !wave_start_i;
  assign is_ret_op = (br_op_i == OP_GETPC) || (br_op_i == OP_SWAPPC);
  assign seq_exp   = pc_o + (PC_W'(instr_len_i) << 2);

  AST_START_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wave_start_i |=> pc_o == ($past(start_addr_i) & ~PC_W'(3))); // R2

  AST_SEQ_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (instr_go && br_op_i == OP_NONE) |=> pc_o == $past(seq_exp)); // R3

  AST_RET_ONLY_OPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (instr_go && !is_ret_op) |=> !ret_valid_o); // R7

  AST_SWAP_RET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (instr_go && br_op_i == OP_SWAPPC) |=> ret_pc_o == $past(seq_exp)); // R8

  AST_SWAP_JUMP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (instr_go && br_op_i == OP_SWAPPC) |=> pc_o == ($past(sreg_i) & ~PC_W'(3))); // R8

  AST_RET_ALIGNED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ret_valid_o |-> ret_pc_o[1:0] == 2'b00); // R9

  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wave_start_i && !instr_valid_i) |=> ($stable(pc_o) && !ret_valid_o)); // R10
endmodule

bind pc_branch_unit pcbr_checker #(.PC_W(PC_W), .LEN_W(LEN_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .wave_start_i  (wave_start_i),
  .start_addr_i  (start_addr_i),
  .instr_valid_i (instr_valid_i),
  .instr_len_i   (instr_len_i),
  .br_op_i       (br_op_i),
  .sreg_i        (sreg_i),
  .pc_o          (pc_o),
  .ret_valid_o   (ret_valid_o),
  .ret_pc_o      (ret_pc_o)
);

// File: tb/pc_branch_unit_tb.sv
module pc_branch_unit_tb;
  localparam int PC_W = 48;

  typedef struct {
    int              due;
    logic [PC_W-1:0] pc;
    logic            rv;
    logic [PC_W-1:0] rp;
    string           req;
  } exp_t;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            wave_start = 1'b0;
  logic [PC_W-1:0] start_addr = '0;
  logic            instr_valid = 1'b0;
  logic [2:0]      instr_len = '0;
  logic [3:0]      br_op = '0;
  logic [15:0]     simm = '0;
  logic            scc = 1'b0, vccz = 1'b0, execz = 1'b0;
  logic [PC_W-1:0] sreg = '0;
  logic [PC_W-1:0] pc;
  logic            ret_valid;
  logic [PC_W-1:0] ret_pc;

  int   n_cmp = 0, n_bad = 0, cyc = 0;
  bit   done = 1'b0;
  exp_t q[$];
  logic [PC_W-1:0] mpc = '0;

  always #4 clk = ~clk;  // 125 MHz

  pc_branch_unit u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wave_start_i(wave_start), .start_addr_i(start_addr),
    .instr_valid_i(instr_valid), .instr_len_i(instr_len), .br_op_i(br_op), .simm_i(simm),
    .scc_i(scc), .vccz_i(vccz), .execz_i(execz), .sreg_i(sreg),
    .pc_o(pc), .ret_valid_o(ret_valid), .ret_pc_o(ret_pc)
  );

  always @(posedge clk) cyc <= cyc + 1;

  task automatic cmp(string req, string what, logic [PC_W-1:0] act, logic [PC_W-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // monitor
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].due == cyc) begin
      exp_t e;
      e = q.pop_front();
      cmp(e.req, "pc_o", pc, e.pc);
      cmp(e.req, "ret_valid_o", PC_W'(ret_valid), PC_W'(e.rv));
      if (e.rv) cmp(e.req, "ret_pc_o", ret_pc, e.rp);
    end
  end

  // driver: applies one cycle of stimulus, pushes expectation due after next edge
  task automatic step(bit st, logic [PC_W-1:0] sa, bit v, logic [2:0] len, logic [3:0] op,
                      logic [15:0] ofs, bit f_scc, bit f_vccz, bit f_execz,
                      logic [PC_W-1:0] sr, string req);
    exp_t e;
    logic [PC_W-1:0] seq, rel;
    bit take;
    @(negedge clk);
    wave_start = st; start_addr = sa; instr_valid = v; instr_len = len; br_op = op;
    simm = ofs; scc = f_scc; vccz = f_vccz; execz = f_execz; sreg = sr;
    seq  = mpc + {43'd0, len, 2'b00};
    rel  = seq + {{30{ofs[15]}}, ofs, 2'b00};
    e.rv = 1'b0; e.rp = '0; e.req = req; e.due = cyc + 1;
    if (st) mpc = {sa[PC_W-1:2], 2'b00};
    else if (v) begin
      case (op)
        4'd1: take = 1'b1;
        4'd2: take = !f_scc;
        4'd3: take = f_scc;
        4'd4: take = f_vccz;
        4'd5: take = !f_vccz;
        4'd6: take = f_execz;
        4'd7: take = !f_execz;
        default: take = 1'b0;
      endcase
      if (op == 4'd9) begin
        e.rv = 1'b1; e.rp = seq; mpc = {sr[PC_W-1:2], 2'b00};
      end else if (op == 4'd8) begin
        e.rv = 1'b1; e.rp = seq; mpc = seq;
      end else mpc = take ? rel : seq;
    end
    e.pc = mpc;
    q.push_back(e);
  endtask

  task automatic start(logic [PC_W-1:0] a, string req);
    step(1, a, 0, 0, 0, 0, 0, 0, 0, 0, req);
  endtask
  task automatic ins(logic [2:0] len, logic [3:0] op, logic [15:0] ofs, bit s, bit vz, bit ez,
                     logic [PC_W-1:0] sr, string req);
    step(0, 0, 1, len, op, ofs, s, vz, ez, sr, req);
  endtask

  // watchdog
  always @(posedge clk) begin
    if (cyc > 20000 && !done) begin
      n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected < 20000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    cmp("R1", "pc_o in reset", pc, '0);
    cmp("R1", "ret_valid_o in reset", PC_W'(ret_valid), '0);
    @(negedge clk); rst_n = 1'b1;

    start(48'h0000_1000_0003, "R2_R9");                 // low bits cleared
    ins(1, 0, 0, 0, 0, 0, 0, "R3");                      // +4
    ins(2, 0, 0, 0, 0, 0, 0, "R3");                      // +8
    ins(1, 4'd12, 16'h0055, 1, 1, 1, 0, "R3");           // unused code is sequential
    ins(1, 1, 16'd4, 0, 0, 0, 0, "R4");                  // forward
    ins(1, 1, 16'hFFFA, 0, 0, 0, 0, "R4");               // backward
    ins(2, 1, 16'd0, 0, 0, 0, 0, "R4");                  // zero offset
    ins(1, 2, 16'd3, 0, 0, 0, 0, "R5");                  // scc0 taken
    ins(1, 2, 16'd3, 1, 0, 0, 0, "R6");
    ins(1, 3, 16'd5, 1, 0, 0, 0, "R5");
    ins(1, 3, 16'd5, 0, 0, 0, 0, "R6");
    ins(1, 4, 16'hFFF0, 0, 1, 0, 0, "R5");
    ins(1, 4, 16'hFFF0, 0, 0, 0, 0, "R6");
    ins(1, 5, 16'd7, 0, 0, 0, 0, "R5");
    ins(1, 5, 16'd7, 0, 1, 0, 0, "R6");
    ins(1, 6, 16'd2, 0, 0, 1, 0, "R5");
    ins(1, 6, 16'd2, 0, 0, 0, 0, "R6");
    ins(1, 7, 16'd9, 0, 0, 0, 0, "R5");
    ins(1, 7, 16'd9, 0, 0, 1, 0, "R6");
    ins(1, 8, 16'd100, 1, 1, 1, 0, "R7");                // offset ignored
    ins(2, 8, 0, 0, 0, 0, 0, "R7");
    ins(1, 9, 0, 0, 0, 0, 48'h0000_0002_0007, "R8_R9");
    ins(3, 9, 0, 0, 0, 0, 48'h0000_ABCD_0000, "R8");
    step(0, 0, 0, 1, 9, 0, 0, 0, 0, 48'h1234, "R10");    // idle: op ignored
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R10");
    step(1, 48'h0000_0000_2000, 1, 1, 1, 16'd8, 0, 0, 0, 0, "R2"); // start wins
    start(48'hFFFF_FFFF_FFF8, "R11");
    ins(3, 0, 0, 0, 0, 0, 0, "R11");                     // wraps to 4
    start(48'h0, "R11");
    ins(1, 1, 16'hFFFE, 0, 0, 0, 0, "R11");              // 4-8 wraps
    ins(1, 9, 0, 0, 0, 0, 48'hFFFF_FFFF_FFFF, "R9");
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R10");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule